// File: doc/BRIEF.md
# Input Link Sample Error Checker

This block watches the data words arriving on two input ports and compares them against reference words held in registers, so that the integrity of a wide source-synchronous data link can be verified before real traffic flows. Each port delivers, per valid strobe, one word captured on the rising edge of its data clock and one captured on the falling edge. The two edges are checked against different references: rising-edge words alternate between reference S0 and S1, and falling-edge words alternate between S2 and S3. The alternation restarts with S0/S2 each time the control register is written.

Every bit position that ever mismatched is remembered in a sticky mask. There are separate masks for rising-edge and falling-edge words, one pair per port. A per-port error flag shows the outcome of the latest compare. Three kinds of event feed a small interrupt unit: a clean compare, a failed compare, and a failure that exposes a bit position not yet recorded. The unit holds write-one-to-clear event flags, an enable per event and an active-low interrupt line.

Software reaches everything through an 8-bit register port with separate write and read addresses. A select register steers pattern and status accesses to port A or port B.

Top module: `sed_link_check`

## Requirements
- R1: After a synchronous reset, every register reads 0, all masks, flags and event flags are clear, and `irq_n` is 1.
- R2: Pattern bytes sit at addresses 1..8 in the order S0 low, S0 high, S1 low, S1 high, S2 low, S2 high, S3 low, S3 high. Each write lands in the port named by the select register (address 16, bit 0: 0 = port A, 1 = port B), and a read at the same address returns it. Read data appears one cycle after `reg_raddr`.
- R3: With compare enabled (address 0, bit 0), the valid strobes of a port alternate between phase 0 and phase 1. Phase 0 checks the rising word against S0 and the falling word against S2. Phase 1 checks against S1 and S3. The first strobe after any control write is phase 0.
- R4: The rising-edge mask of the selected port (address 9 low byte, 10 high byte) ORs in the XOR of each rising word with its reference. Bits stay set until the control register is written.
- R5: The falling-edge mask (address 11 low byte, 12 high byte) is kept separately and is updated only by falling-word mismatches.
- R6: Address 13 bit 0 (port A) and bit 1 (port B) read 1 when that port's latest compare mismatched, and 0 when it matched.
- R7: While compare is disabled, valid strobes change no mask, no port flag, no phase and no event flag.
- R8: Any write to address 0 clears both masks and the flag of both ports, and resets both phases to 0.
- R9: Event flags at address 14 are sticky. Bit 0 is set by a fully matching compare. Bit 1 is set by any mismatch. Bit 2 is set by a mismatch in a bit position not already set in the mask it goes to. Writing 1 to a bit clears it, and a new event in the same cycle wins over the clear.
- R10: `irq_n` is low exactly when some event flag is set and its enable (address 15, same bit order) is 1. It follows the flags with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 5 | Register read address |
| reg_rdata | output | 8 | Registered read data |
| a_vld | input | 1 | Port A word pair valid |
| a_rise | input | 16 | Port A rising-edge word |
| a_fall | input | 16 | Port A falling-edge word |
| b_vld | input | 1 | Port B word pair valid |
| b_rise | input | 16 | Port B rising-edge word |
| b_fall | input | 16 | Port B falling-edge word |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench goes after phase ordering by sending words that match S1/S3 on a phase-0 strobe. A checker that ignored the alternation, or that failed to restart it on a control write, would miss that mismatch or flag a good pair. Falling-only mismatches check that the rising mask stays untouched, which catches a design that shares one mask between the edges. A write-one-to-clear that lands in the same cycle as a new failure checks that the event survives rather than being lost. Disabled strobes carrying garbage check that nothing moves while compare is off.

// File: rtl/sed_pkg.sv
package sed_pkg;
  localparam int SED_DW    = 16;
  localparam int SED_NPAIR = 2;
  localparam int SED_AW    = 5;
  localparam int SED_NPORT = 2;
  localparam int SED_NEV   = 3;

  // bit 0 pass, bit 1 fail, bit 2 new error bit
  typedef struct packed {
    logic newbit;
    logic fail;
    logic pass;
  } sed_evt_t;
endpackage

// File: rtl/sed_port_check.sv
module sed_port_check
  import sed_pkg::*;
#(
  parameter int DW    = SED_DW,
  parameter int NPAIR = SED_NPAIR
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         en,
  input  logic                         vld,
  input  logic [DW-1:0]                rise_d,
  input  logic [DW-1:0]                fall_d,
  input  logic [2*NPAIR-1:0][DW-1:0]   pats,
  output logic [DW-1:0]                rise_mask,
  output logic [DW-1:0]                fall_mask,
  output logic                         err,
  output sed_evt_t                     evt
);
  localparam int NPAT = 2 * NPAIR;
  localparam int PW   = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int IW   = (NPAT > 1) ? $clog2(NPAT) : 1;

  logic [PW-1:0] phase;
  logic [IW-1:0] ridx, fidx;
  logic [DW-1:0] rdiff, fdiff;
  logic          hit, any_diff;

  always_comb begin
    ridx     = IW'(phase);
    fidx     = IW'(NPAIR) + IW'(phase);
    rdiff    = rise_d ^ pats[ridx];
    fdiff    = fall_d ^ pats[fidx];
    hit      = en && vld && !clr;
    any_diff = |{rdiff, fdiff};
    evt.pass   = hit && !any_diff;
    evt.fail   = hit && any_diff;
    evt.newbit = hit && (|(rdiff & ~rise_mask) || |(fdiff & ~fall_mask));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rise_mask <= '0;
      fall_mask <= '0;
      err       <= 1'b0;
      phase     <= '0;
    end else if (hit) begin
      rise_mask <= rise_mask | rdiff;
      fall_mask <= fall_mask | fdiff;
      err       <= any_diff;
      phase     <= (phase == PW'(NPAIR - 1)) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/sed_irq.sv
module sed_irq
  import sed_pkg::*;
#(
  parameter int NEV = SED_NEV
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev_set,
  input  logic [NEV-1:0] ev_w1c,
  input  logic [NEV-1:0] ev_en,
  output logic [NEV-1:0] ev_flags,
  output logic           irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_flags <= '0;
      irq_n    <= 1'b1;
    end else begin
      ev_flags <= (ev_flags & ~ev_w1c) | ev_set;
      irq_n    <= ~|(ev_flags & ev_en);
    end
  end
endmodule

// File: rtl/sed_regs.sv
module sed_regs
  import sed_pkg::*;
#(
  parameter int DW    = SED_DW,
  parameter int NPAIR = SED_NPAIR,
  parameter int AW    = SED_AW,
  parameter int NPORT = SED_NPORT,
  parameter int NEV   = SED_NEV
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   we,
  input  logic [AW-1:0]                          waddr,
  input  logic [7:0]                             wdata,
  input  logic [AW-1:0]                          raddr,
  input  logic [NPORT-1:0][DW-1:0]               rise_mask,
  input  logic [NPORT-1:0][DW-1:0]               fall_mask,
  input  logic [NPORT-1:0]                       port_err,
  input  logic [NEV-1:0]                         ev_flags,
  output logic [7:0]                             rdata,
  output logic                                   cmp_en,
  output logic                                   ctrl_wr,
  output logic [NPORT-1:0][2*NPAIR-1:0][DW-1:0]  pats,
  output logic [NEV-1:0]                         ev_w1c,
  output logic [NEV-1:0]                         irq_en
);
  localparam int NPAT      = 2 * NPAIR;
  localparam int BPW       = DW / 8;
  localparam int SW        = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int A_CTRL    = 0;
  localparam int PAT_BASE  = 1;
  localparam int STAT_BASE = PAT_BASE + NPAT * BPW;
  localparam int A_PFLAG   = STAT_BASE + 2 * BPW;
  localparam int A_EVT     = A_PFLAG + 1;
  localparam int A_IEN     = A_EVT + 1;
  localparam int A_SEL     = A_IEN + 1;

  logic [SW-1:0] sel_q;
  logic [7:0]    rd_mux;

  assign ctrl_wr = we && (waddr == AW'(A_CTRL));
  assign ev_w1c  = (we && (waddr == AW'(A_EVT))) ? wdata[NEV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_en <= 1'b0;
      sel_q  <= '0;
      irq_en <= '0;
      pats   <= '0;
      rdata  <= '0;
    end else begin
      if (ctrl_wr) cmp_en <= wdata[0];
      if (we && waddr == AW'(A_IEN)) irq_en <= wdata[NEV-1:0];
      if (we && waddr == AW'(A_SEL)) sel_q <= wdata[SW-1:0];
      for (int w = 0; w < NPAT; w++) begin
        for (int b = 0; b < BPW; b++) begin
          if (we && waddr == AW'(PAT_BASE + w * BPW + b))
            pats[sel_q][w][b*8 +: 8] <= wdata;
        end
      end
      rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (raddr == AW'(A_CTRL))  rd_mux = {7'b0, cmp_en};
    if (raddr == AW'(A_PFLAG)) rd_mux = 8'(port_err);
    if (raddr == AW'(A_EVT))   rd_mux = 8'(ev_flags);
    if (raddr == AW'(A_IEN))   rd_mux = 8'(irq_en);
    if (raddr == AW'(A_SEL))   rd_mux = 8'(sel_q);
    for (int w = 0; w < NPAT; w++) begin
      for (int b = 0; b < BPW; b++) begin
        if (raddr == AW'(PAT_BASE + w * BPW + b))
          rd_mux = pats[sel_q][w][b*8 +: 8];
      end
    end
    for (int b = 0; b < BPW; b++) begin
      if (raddr == AW'(STAT_BASE + b))       rd_mux = rise_mask[sel_q][b*8 +: 8];
      if (raddr == AW'(STAT_BASE + BPW + b)) rd_mux = fall_mask[sel_q][b*8 +: 8];
    end
  end
endmodule

// File: rtl/sed_link_check.sv
module sed_link_check
  import sed_pkg::*;
#(
  parameter int DW    = SED_DW,
  parameter int NPAIR = SED_NPAIR,
  parameter int AW    = SED_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [7:0]    reg_rdata,
  input  logic          a_vld,
  input  logic [DW-1:0] a_rise,
  input  logic [DW-1:0] a_fall,
  input  logic          b_vld,
  input  logic [DW-1:0] b_rise,
  input  logic [DW-1:0] b_fall,
  output logic          irq_n
);
  localparam int NPORT = SED_NPORT;
  localparam int NEV   = SED_NEV;

  logic [NPORT-1:0]                      vld_v;
  logic [NPORT-1:0][DW-1:0]              rise_v, fall_v;
  logic [NPORT-1:0][DW-1:0]              rise_mask, fall_mask;
  logic [NPORT-1:0]                      port_err;
  logic [NPORT-1:0][2*NPAIR-1:0][DW-1:0] pats;
  sed_evt_t [NPORT-1:0]                  port_evt;
  logic [NEV-1:0]                        ev_set, ev_w1c, ev_flags, irq_en;
  logic                                  cmp_en, ctrl_wr;

  assign vld_v  = {b_vld, a_vld};
  assign rise_v = {b_rise, a_rise};
  assign fall_v = {b_fall, a_fall};

  sed_regs #(.DW(DW), .NPAIR(NPAIR), .AW(AW), .NPORT(NPORT), .NEV(NEV)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rise_mask(rise_mask), .fall_mask(fall_mask),
    .port_err(port_err), .ev_flags(ev_flags), .rdata(reg_rdata),
    .cmp_en(cmp_en), .ctrl_wr(ctrl_wr), .pats(pats), .ev_w1c(ev_w1c),
    .irq_en(irq_en)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sed_port_check #(.DW(DW), .NPAIR(NPAIR)) u_chk (
      .clk(clk), .rst(rst), .clr(ctrl_wr), .en(cmp_en), .vld(vld_v[p]),
      .rise_d(rise_v[p]), .fall_d(fall_v[p]), .pats(pats[p]),
      .rise_mask(rise_mask[p]), .fall_mask(fall_mask[p]),
      .err(port_err[p]), .evt(port_evt[p])
    );
  end

  always_comb begin
    ev_set = '0;
    for (int p = 0; p < NPORT; p++) ev_set = ev_set | NEV'(port_evt[p]);
  end

  sed_irq #(.NEV(NEV)) u_irq (
    .clk(clk), .rst(rst), .ev_set(ev_set), .ev_w1c(ev_w1c), .ev_en(irq_en),
    .ev_flags(ev_flags), .irq_n(irq_n)
  );
endmodule

// File: rtl/sed_link_check_chk.sv
module sed_link_check_chk #(
  parameter int DW    = 16,
  parameter int AW    = 5,
  parameter int NPORT = 2,
  parameter int NEV   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_we,
  input logic [AW-1:0]            reg_addr,
  input logic [NPORT-1:0][DW-1:0] rise_mask,
  input logic [NPORT-1:0][DW-1:0] fall_mask,
  input logic [NPORT-1:0]         port_err,
  input logic                     cmp_en,
  input logic [NEV-1:0]           ev_flags,
  input logic [NEV-1:0]           irq_en,
  input logic                     irq_n
);
  logic started;
  logic ctl_w, evt_w;
  always_ff @(posedge clk) started <= 1'b1;
  assign ctl_w = reg_we && (reg_addr == AW'(0));
  assign evt_w = reg_we && (reg_addr == AW'(14));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_n && ev_flags == '0 && rise_mask == '0 && fall_mask == '0 && port_err == '0));

  // R4
  rise_sticky_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !ctl_w |=> ((rise_mask & $past(rise_mask)) == $past(rise_mask)));

  // R5
  fall_sticky_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !ctl_w |=> ((fall_mask & $past(fall_mask)) == $past(fall_mask)));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst || !started)
    (!cmp_en && !ctl_w) |=> ($stable(rise_mask) && $stable(fall_mask) && $stable(port_err)));

  // R8
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (rst || !started)
    ctl_w |=> (rise_mask == '0 && fall_mask == '0 && port_err == '0));

  // R9
  event_sticky_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !evt_w |=> ((ev_flags & $past(ev_flags)) == $past(ev_flags)));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !$past(rst) |-> (irq_n == !(|($past(ev_flags) & $past(irq_en)))));
endmodule

bind sed_link_check sed_link_check_chk #(.DW(DW), .AW(AW), .NPORT(NPORT), .NEV(NEV)) u_sva (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .rise_mask(rise_mask), .fall_mask(fall_mask), .port_err(port_err),
  .cmp_en(cmp_en), .ev_flags(ev_flags), .irq_en(irq_en), .irq_n(irq_n)
);

// File: tb/sed_link_check_tb.sv
module sed_link_check_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0, reg_raddr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        a_vld = 1'b0, b_vld = 1'b0;
  logic [15:0] a_rise = '0, a_fall = '0, b_rise = '0, b_fall = '0;
  logic        irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] mpat [2][4];
  logic [15:0] mr [2], mf [2];
  logic        merr [2];
  int          mph [2];
  logic [2:0]  mev, mien;
  logic        men, msel;

  always #4 clk = ~clk;

  sed_link_check u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .a_vld(a_vld), .a_rise(a_rise), .a_fall(a_fall),
    .b_vld(b_vld), .b_rise(b_rise), .b_fall(b_fall), .irq_n(irq_n)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_raddr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [2:0] mdl_port(int p, logic v, logic [15:0] r, logic [15:0] f);
    logic [15:0] dr, df;
    logic [2:0] s;
    s = '0;
    if (men && v) begin
      dr = r ^ mpat[p][mph[p]];
      df = f ^ mpat[p][2 + mph[p]];
      s[0] = (dr | df) == 0;
      s[1] = (dr | df) != 0;
      s[2] = |(dr & ~mr[p]) || |(df & ~mf[p]);
      mr[p] = mr[p] | dr;
      mf[p] = mf[p] | df;
      merr[p] = s[1];
      mph[p] = 1 - mph[p];
    end
    return s;
  endfunction

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 0) begin
      men = d[0];
      for (int p = 0; p < 2; p++) begin mr[p] = 0; mf[p] = 0; merr[p] = 0; mph[p] = 0; end
    end
    if (a == 14) mev = mev & ~d[2:0];
    if (a == 15) mien = d[2:0];
    if (a == 16) msel = d[0];
    if (a >= 1 && a <= 8) begin
      if (a[0]) mpat[msel][(a-1)/2][7:0] = d;
      else      mpat[msel][(a-1)/2][15:8] = d;
    end
  endtask

  // word pair on both ports, optional simultaneous event clear
  task automatic smp(logic va, logic [15:0] ra, logic [15:0] fa,
                     logic vb, logic [15:0] rb, logic [15:0] fb,
                     logic cw, logic [2:0] cd);
    logic [2:0] s;
    @(negedge clk);
    a_vld = va; a_rise = ra; a_fall = fa;
    b_vld = vb; b_rise = rb; b_fall = fb;
    reg_we = cw; reg_addr = 5'd14; reg_wdata = {5'b0, cd};
    @(negedge clk);
    a_vld = 0; b_vld = 0; reg_we = 0;
    s = mdl_port(0, va, ra, fa) | mdl_port(1, vb, rb, fb);
    mev = (mev & ~(cw ? cd : 3'b0)) | s;
  endtask

  task automatic check_all(string ctx);
    logic [7:0] lo, hi;
    for (int p = 0; p < 2; p++) begin
      wr(16, 8'(p));
      rd(9, lo);  rd(10, hi); chk($sformatf("R4 rise mask port%0d %s", p, ctx), {hi, lo}, mr[p]);
      rd(11, lo); rd(12, hi); chk($sformatf("R5 fall mask port%0d %s", p, ctx), {hi, lo}, mf[p]);
    end
    rd(13, lo); chk({"R6 port flags ", ctx}, lo, {6'b0, merr[1], merr[0]});
    rd(14, lo); chk({"R9 event flags ", ctx}, lo, {5'b0, mev});
    chk({"R10 irq_n ", ctx}, irq_n, !(|(mev & mien)));
  endtask

  task automatic load_pats(int p);
    wr(16, 8'(p));
    for (int w = 0; w < 4; w++) begin
      wr(5'(1 + 2*w), mpat[p][w][7:0] ^ 8'h00);
      wr(5'(2 + 2*w), mpat[p][w][15:8]);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] x;
    void'($urandom(32'd4242));
    for (int p = 0; p < 2; p++) begin
      mr[p] = 0; mf[p] = 0; merr[p] = 0; mph[p] = 0;
      for (int w = 0; w < 4; w++) mpat[p][w] = 0;
    end
    mev = 0; mien = 0; men = 0; msel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq_n after reset", irq_n, 1);
    rd(0, d);  chk("R1 control after reset", d, 0);
    rd(14, d); chk("R1 events after reset", d, 0);
    rd(3, d);  chk("R1 pattern after reset", d, 0);
    check_all("reset");

    // R2 patterns per port
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 4; w++) mpat[p][w] = 16'($urandom);
    mpat[0][1] = 16'hA55A; mpat[0][3] = 16'h0FF0;
    load_pats(0); load_pats(1);
    for (int p = 0; p < 2; p++) begin
      wr(16, 8'(p));
      for (int w = 0; w < 4; w++) begin
        rd(5'(1 + 2*w), d); chk($sformatf("R2 S%0d low port%0d", w, p), d, mpat[p][w][7:0]);
        rd(5'(2 + 2*w), d); chk($sformatf("R2 S%0d high port%0d", w, p), d, mpat[p][w][15:8]);
      end
    end

    // R7 disabled: garbage ignored
    smp(1, 16'hFFFF, 16'h1234, 1, 16'h0, 16'h0, 0, 0);
    check_all("R7 disabled");

    // R3 enable, matching pairs in phase order
    wr(15, 8'h7);
    wr(0, 8'h1);
    smp(1, mpat[0][0], mpat[0][2], 1, mpat[1][0], mpat[1][2], 0, 0);
    smp(1, mpat[0][1], mpat[0][3], 0, 0, 0, 0, 0);
    check_all("R3 in-order match");
    // wrong phase: port A phase 0 again, send S1/S3
    smp(1, mpat[0][1], mpat[0][3], 0, 0, 0, 0, 0);
    check_all("R3 swapped phase");

    // R8 clear, then R5 falling-only error
    wr(0, 8'h1);
    check_all("R8 after control write");
    wr(14, 8'h7);
    smp(0, 0, 0, 1, mpat[1][0], mpat[1][2] ^ 16'h8001, 0, 0);
    check_all("R5 fall only");
    // R6 flag returns low after a match (phase 1 now)
    smp(0, 0, 0, 1, mpat[1][1], mpat[1][3], 0, 0);
    check_all("R6 flag recovers");

    // R9 set wins over same-cycle clear
    smp(0, 0, 0, 1, mpat[1][0] ^ 16'h0100, mpat[1][2], 1, 3'h7);
    check_all("R9 set beats clear");
    wr(14, 8'h2);
    check_all("R9 partial clear");

    // R10 enable subsets
    wr(15, 8'h1);
    repeat (2) @(negedge clk);
    check_all("R10 pass only enabled");
    wr(14, 8'h7); wr(15, 8'h0);
    repeat (2) @(negedge clk);
    check_all("R10 none enabled");

    // constrained random
    wr(15, 8'($urandom_range(0, 7)));
    for (int i = 0; i < 400; i++) begin
      logic va, vb;
      logic [15:0] ra, fa, rb, fb;
      va = 1'($urandom); vb = 1'($urandom);
      ra = mpat[0][mph[0]];     fa = mpat[0][2 + mph[0]];
      rb = mpat[1][mph[1]];     fb = mpat[1][2 + mph[1]];
      if ($urandom_range(0, 3) == 0) ra ^= 16'(1) << $urandom_range(0, 15);
      if ($urandom_range(0, 3) == 0) fa ^= 16'(1) << $urandom_range(0, 15);
      if ($urandom_range(0, 5) == 0) rb ^= 16'($urandom);
      if ($urandom_range(0, 5) == 0) fb ^= 16'($urandom);
      x = 16'($urandom);
      smp(va, ra, fa, vb, rb, fb, x[0] & x[1], x[4:2]);
      if (x[15:12] == 0) wr(0, 8'(x[5] | x[6]));
      if (x[11:9] == 0) wr(15, 8'(x[8:6]));
      if (i % 25 == 24) check_all($sformatf("random %0d", i));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule